// File: doc/BRIEF.md
# Chopped Incremental Sinc3 Decimator

This block is the digital back end of a light-to-digital signal chain built around an incremental delta-sigma modulator. The whole analog path, from the sensor bias to the modulator output, is chopped by a system-level chop signal, and the block drives that signal itself. One conversion is a fixed number of chop phases. In each phase a third-order cascade of integrators is cleared and then fed a fixed number of modulator samples. Its final value is that phase's sinc result.

Chopping flips the sign of the wanted signal between phases but leaves any offset unchanged. The block therefore negates the results of odd phases and sums all phases in a short moving-average FIR. This recovers the signal and cancels the offset, and because the average spans several full phases it also suppresses slow mains interference. The sum is divided by the tap count with rounding and then clamped to a signed output word.

Each conversion ends with a one-cycle done pulse. After that pulse the block requests sleep until the next start arrives.

Top module: `chopped_incr_decim`

## Requirements
- R1: A synchronous active-high `rst` puts the block in idle, whether or not a conversion is running. In idle, `busy`, `done`, `sleep_req` and `sys_chop` are 0 and `result` is 0. A conversion started after the reset gives the same value it would give from power-up.
- R2: When `start` is high in a cycle where the block is idle, `busy` rises at the next clock edge. When `start` is high during a conversion, it is ignored: neither the result nor the timing of that conversion changes.
- R3: A conversion is NTAPS phases, and each phase takes OSR accepted samples. A sample with `mod_bit`=1 counts as +1 and one with `mod_bit`=0 counts as -1. The phase value is the last stage of a three-stage integrator cascade that is cleared at the start of the phase, updated as i1+=x, then i2+=i1, then i3+=i2. For OSR=64, an input of all +1 gives 45760.
- R4: `sys_chop` is 0 during phase 0 and toggles at the clock edge that accepts the last sample of each phase. Because NTAPS is even, it is back at 0 when the conversion ends.
- R5: Phase values taken while `sys_chop`=1 are negated and then summed. A bitstream that does not follow the chop signal, such as a pure offset, therefore gives a result of 0.
- R6: The signed sum is rounded as (sum + NTAPS/2) shifted arithmetically right by log2(NTAPS). NTAPS is an even power of two.
- R7: The rounded value is saturated to OUT_W-bit two's complement, which for OUT_W=18 is the range -131072 to 131071.
- R8: `done` is high for exactly one cycle, starting at the edge that accepts the final sample. `result` updates at that same edge and holds its value until the next `done`. `busy` is low whenever `done` is high.
- R9: `sleep_req` goes high together with `done` and stays high until the next accepted `start`.
- R10: A cycle with `mod_valid` low is not counted as a sample and does not advance the conversion. Samples that arrive while the block is idle are also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion request, honoured only when idle |
| mod_bit | input | 1 | Modulator output bit (1 = +1, 0 = -1) |
| mod_valid | input | 1 | Qualifies `mod_bit` as one modulator sample |
| sys_chop | output | 1 | System chop phase driven to the analog chain |
| busy | output | 1 | A conversion is in progress |
| done | output | 1 | One-cycle pulse: `result` is new |
| sleep_req | output | 1 | Request to power the analog chain down |
| result | output | OUT_W | Signed, rounded and saturated conversion result |

## Verification
Some properties hold on every cycle and are checked by assertions. These are the shape of the handshake: `done` lasting a single cycle, `result` holding between done pulses, `busy` rising only after a start, and sleep being requested at done and dropped when work resumes. They also cover the chop signal, which must rest low while idle and change only on an accepted sample. The numeric behaviour can only be shown by the bench's scenarios, because it depends on the whole history of a conversion. That covers the cascade arithmetic, offset cancellation through chop-sign correction, rounding at the half-LSB points, saturation at both rails, and immunity to gaps, stray starts and resets in mid-conversion.

// File: rtl/cid_pkg.sv
package cid_pkg;

    // Per-cycle control from the sequencer to the datapath
    typedef struct packed {
        logic take;       // a modulator sample is accepted this cycle
        logic phase_end;  // accepted sample is the last of its phase
        logic conv_end;   // ... and that phase is the last of the conversion
        logic invert;     // current phase carries negated signal polarity
    } cid_step_t;

    // Integrator width that can hold the worst-case cascade value
    function automatic int acc_width(input int osr, input int order);
        return order * $clog2(osr) + 1;
    endfunction

endpackage

// File: rtl/cid_seq.sv
module cid_seq
    import cid_pkg::*;
#(
    parameter int OSR   = 64,
    parameter int NTAPS = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      mod_valid,
    output logic      launch,
    output cid_step_t step,
    output logic      busy,
    output logic      sys_chop,
    output logic      done,
    output logic      sleep_req
);
    localparam int CNT_W = $clog2(OSR);
    localparam int PH_W  = $clog2(NTAPS);

    logic [CNT_W-1:0] cnt_q;
    logic [PH_W-1:0]  ph_q;
    logic             busy_q, chop_q, done_q, sleep_q;

    always_comb begin
        launch         = start && !busy_q;
        step.take      = busy_q && mod_valid;
        step.phase_end = step.take && (cnt_q == CNT_W'(OSR - 1));
        step.conv_end  = step.phase_end && (ph_q == PH_W'(NTAPS - 1));
        step.invert    = chop_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            ph_q    <= '0;
            busy_q  <= 1'b0;
            chop_q  <= 1'b0;
            done_q  <= 1'b0;
            sleep_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (launch) begin
                busy_q  <= 1'b1;
                cnt_q   <= '0;
                ph_q    <= '0;
                chop_q  <= 1'b0;
                sleep_q <= 1'b0;
            end else if (step.take) begin
                if (step.phase_end) begin
                    cnt_q  <= '0;
                    chop_q <= !chop_q;
                    if (step.conv_end) begin
                        busy_q  <= 1'b0;
                        ph_q    <= '0;
                        done_q  <= 1'b1;
                        sleep_q <= 1'b1;
                    end else begin
                        ph_q <= ph_q + 1'b1;
                    end
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign busy      = busy_q;
    assign sys_chop  = chop_q;
    assign done      = done_q;
    assign sleep_req = sleep_q;

endmodule

// File: rtl/cid_sinc3.sv
module cid_sinc3 #(
    parameter int ORDER = 3,
    parameter int ACC_W = 19
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    launch,
    input  logic                    take,
    input  logic                    phase_end,
    input  logic                    mod_bit,
    output logic signed [ACC_W-1:0] phase_val
);
    logic signed [ACC_W-1:0] x;
    logic signed [ACC_W-1:0] acc_q [ORDER];
    logic signed [ACC_W-1:0] acc_d [ORDER];

    // Cascade of integrators; comb registers are empty at the single
    // per-phase output, so the sinc3 value is the last integrator.
    always_comb begin
        x        = mod_bit ? ACC_W'(1) : '1;
        acc_d[0] = acc_q[0] + x;
        for (int s = 1; s < ORDER; s++) begin
            acc_d[s] = acc_q[s] + acc_d[s-1];
        end
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < ORDER; s++) begin
            if (rst || launch) begin
                acc_q[s] <= '0;
            end else if (take) begin
                acc_q[s] <= phase_end ? '0 : acc_d[s];
            end
        end
    end

    assign phase_val = acc_d[ORDER-1];

endmodule

// File: rtl/cid_chopavg.sv
module cid_chopavg
    import cid_pkg::*;
#(
    parameter int ACC_W = 19,
    parameter int NTAPS = 4,
    parameter int OUT_W = 18
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    launch,
    input  cid_step_t               step,
    input  logic signed [ACC_W-1:0] phase_val,
    output logic signed [OUT_W-1:0] result
);
    localparam int SH    = $clog2(NTAPS);
    localparam int SUM_W = ACC_W + SH + 1;
    localparam logic signed [SUM_W-1:0] HALF = SUM_W'(NTAPS / 2);
    localparam logic signed [SUM_W-1:0] MAXV = SUM_W'(2 ** (OUT_W - 1) - 1);
    localparam logic signed [SUM_W-1:0] MINV = -MAXV - SUM_W'(1);

    logic signed [SUM_W-1:0] ext, term, sum_q, sum_d, rounded;
    logic signed [OUT_W-1:0] clamped, result_q;

    always_comb begin
        ext     = {{(SUM_W - ACC_W){phase_val[ACC_W-1]}}, phase_val};
        term    = step.invert ? -ext : ext;
        sum_d   = sum_q + term;
        rounded = (sum_d + HALF) >>> SH;
        if (rounded > MAXV) begin
            clamped = MAXV[OUT_W-1:0];
        end else if (rounded < MINV) begin
            clamped = MINV[OUT_W-1:0];
        end else begin
            clamped = rounded[OUT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q    <= '0;
            result_q <= '0;
        end else if (launch) begin
            sum_q <= '0;
        end else if (step.take && step.phase_end) begin
            sum_q <= step.conv_end ? '0 : sum_d;
            if (step.conv_end) begin
                result_q <= clamped;
            end
        end
    end

    assign result = result_q;

endmodule

// File: rtl/chopped_incr_decim.sv
module chopped_incr_decim
    import cid_pkg::*;
#(
    parameter int OSR   = 64,
    parameter int NTAPS = 4,
    parameter int OUT_W = 18
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    mod_bit,
    input  logic                    mod_valid,
    output logic                    sys_chop,
    output logic                    busy,
    output logic                    done,
    output logic                    sleep_req,
    output logic signed [OUT_W-1:0] result
);
    localparam int ORDER = 3;
    localparam int ACC_W = acc_width(OSR, ORDER);

    cid_step_t               step;
    logic                    launch;
    logic signed [ACC_W-1:0] phase_val;

    cid_seq #(.OSR(OSR), .NTAPS(NTAPS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .mod_valid (mod_valid),
        .launch    (launch),
        .step      (step),
        .busy      (busy),
        .sys_chop  (sys_chop),
        .done      (done),
        .sleep_req (sleep_req)
    );

    cid_sinc3 #(.ORDER(ORDER), .ACC_W(ACC_W)) u_sinc (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .take      (step.take),
        .phase_end (step.phase_end),
        .mod_bit   (mod_bit),
        .phase_val (phase_val)
    );

    cid_chopavg #(.ACC_W(ACC_W), .NTAPS(NTAPS), .OUT_W(OUT_W)) u_avg (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .step      (step),
        .phase_val (phase_val),
        .result    (result)
    );

endmodule

// File: rtl/cid_checker.sv
module cid_checker #(
    parameter int OUT_W = 18
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             mod_valid,
    input logic             sys_chop,
    input logic             busy,
    input logic             done,
    input logic             sleep_req,
    input logic [OUT_W-1:0] result
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!busy && !done && !sleep_req && !sys_chop && result == '0)); // R1

    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start)); // R2

    AST_CHOP_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sys_chop); // R4

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R8

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result)); // R8

    AST_SLEEP_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> sleep_req); // R9

    AST_SLEEP_DROPS: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !sleep_req); // R9

    AST_CHOP_ON_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        !$stable(sys_chop) |-> $past(busy && mod_valid)); // R10

    AST_HOLD_WITHOUT_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        (busy && !mod_valid) |=> busy); // R10

endmodule

bind chopped_incr_decim cid_checker #(.OUT_W(OUT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .mod_valid (mod_valid),
    .sys_chop  (sys_chop),
    .busy      (busy),
    .done      (done),
    .sleep_req (sleep_req),
    .result    (result)
);

// File: tb/tb_chopped_incr_decim.sv
module tb_chopped_incr_decim;
    localparam int CLK_PERIOD = 10;
    localparam int OUT_W      = 18;
    localparam int NTAPS      = 4;
    localparam int NVEC       = 11;

    // {dut select (0: OSR 64, 1: OSR 128), stimulus mode, expected result}
    localparam int VEC [NVEC][3] = '{
        '{0, 0,  45760}, '{0, 1, -45760}, '{0, 2, 0},     '{0, 3, 0},
        '{0, 4,   1056}, '{0, 5,  33792}, '{0, 6, 0},     '{0, 7, 1},
        '{0, 8,     -1}, '{1, 0, 131071}, '{1, 1, -131072}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_a = 1'b0, start_b = 1'b0;
    logic mod_bit = 1'b0, mod_valid = 1'b0;
    logic chop_a, busy_a, done_a, sleep_a;
    logic chop_b, busy_b, done_b, sleep_b;
    logic signed [OUT_W-1:0] res_a, res_b;
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = !clk;

    chopped_incr_decim #(.OSR(64), .NTAPS(NTAPS), .OUT_W(OUT_W)) dut (
        .clk(clk), .rst(rst), .start(start_a), .mod_bit(mod_bit),
        .mod_valid(mod_valid), .sys_chop(chop_a), .busy(busy_a),
        .done(done_a), .sleep_req(sleep_a), .result(res_a)
    );

    chopped_incr_decim #(.OSR(128), .NTAPS(NTAPS), .OUT_W(OUT_W)) dut_sat (
        .clk(clk), .rst(rst), .start(start_b), .mod_bit(mod_bit),
        .mod_valid(mod_valid), .sys_chop(chop_b), .busy(busy_b),
        .done(done_b), .sleep_req(sleep_b), .result(res_b)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Bitstream patterns; c is the chop level seen on the port
    function automatic logic gen(input int mode, input int p, input int k,
                                 input int osr, input logic c);
        case (mode)
            0: return !c;                              // signal +1, follows chop
            1: return c;                               // signal -1, follows chop
            2: return 1'b1;                            // pure offset
            3: return 1'b0;                            // pure offset
            4: return (k % 2 == 0) ^ c;                // alternating
            5: return (k < osr / 2) ^ c;               // half +1, half -1
            6: return !(p == 0 && k == osr - 1);       // rounding -0.5
            7: return !(p == 1 && k == osr - 1);       // rounding +0.5
            default: return !((p == 0 || p == 2) && k == osr - 1); // -1.0
        endcase
    endfunction

    task automatic run_conv(input int sel, input int mode, input int exp,
                            input bit gaps, input bit poke, input string req);
        int osr;
        logic c;
        osr = (sel != 0) ? 128 : 64;
        @(negedge clk);
        if (sel != 0) start_b = 1'b1; else start_a = 1'b1;
        @(negedge clk);
        start_a = 1'b0;
        start_b = 1'b0;
        check(((sel != 0) ? busy_b : busy_a) == 1'b1, "R2 busy after start",
              (sel != 0) ? busy_b : busy_a, 1);
        check(((sel != 0) ? sleep_b : sleep_a) == 1'b0, "R9 sleep cleared by start",
              (sel != 0) ? sleep_b : sleep_a, 0);
        for (int p = 0; p < NTAPS; p++) begin
            for (int k = 0; k < osr; k++) begin
                if (gaps) begin
                    mod_valid = 1'b0;
                    mod_bit   = !mod_bit;
                    @(negedge clk);
                end
                c = (sel != 0) ? chop_b : chop_a;
                if (k == 0) check(c == p[0], "R4 chop level per phase", c, p[0]);
                mod_valid = 1'b1;
                mod_bit   = gen(mode, p, k, osr, c);
                if (sel == 0) start_a = poke && p == 1 && k == 3;
                if (!(p == NTAPS - 1 && k == osr - 1)) @(negedge clk);
            end
        end
        @(posedge clk);
        #1;
        check(((sel != 0) ? done_b : done_a) == 1'b1, "R8 done at final sample",
              (sel != 0) ? done_b : done_a, 1);
        check(((sel != 0) ? res_b : res_a) == exp, req,
              (sel != 0) ? res_b : res_a, exp);
        @(negedge clk);
        mod_valid = 1'b0;
        start_a   = 1'b0;
        @(posedge clk);
        #1;
        check(((sel != 0) ? done_b : done_a) == 1'b0, "R8 done lasts one cycle",
              (sel != 0) ? done_b : done_a, 0);
        check(((sel != 0) ? res_b : res_a) == exp, "R8 result held",
              (sel != 0) ? res_b : res_a, exp);
        check(((sel != 0) ? sleep_b : sleep_a) == 1'b1, "R9 sleep after done",
              (sel != 0) ? sleep_b : sleep_a, 1);
        check(((sel != 0) ? chop_b : chop_a) == 1'b0, "R4 chop low at end",
              (sel != 0) ? chop_b : chop_a, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(busy_a == 0 && done_a == 0 && sleep_a == 0 && chop_a == 0,
              "R1 reset control outputs", {busy_a, done_a, sleep_a, chop_a}, 0);
        check(res_a == 0, "R1 reset result", res_a, 0);
        rst = 1'b0;

        // Vector table: R3 main value, R5 offset, R6 rounding, R7 saturation
        for (int i = 0; i < NVEC; i++) begin
            string tag;
            if (VEC[i][0] != 0)                        tag = "R7 saturation";
            else if (VEC[i][1] == 2 || VEC[i][1] == 3) tag = "R5 offset cancels";
            else if (VEC[i][1] >= 6)                   tag = "R6 rounding";
            else                                       tag = "R3 cascade value";
            run_conv(VEC[i][0], VEC[i][1], VEC[i][2], 1'b0, 1'b0, tag);
        end

        // R10: idle dut ignored the samples fed to the other instance
        check(busy_a == 0 && res_a == -45760 + 45759, "R10 idle samples ignored",
              res_a, -1);

        // R10: gaps in mod_valid do not change the value
        run_conv(0, 5, 33792, 1'b1, 1'b0, "R10 gaps ignored");

        // R2: start during a conversion is ignored
        run_conv(0, 0, 45760, 1'b0, 1'b1, "R2 start while busy ignored");

        // R1: reset during a conversion
        @(negedge clk);
        start_a = 1'b1;
        @(negedge clk);
        start_a = 1'b0;
        for (int k = 0; k < 100; k++) begin
            mod_valid = 1'b1;
            mod_bit   = !chop_a;
            @(negedge clk);
        end
        mod_valid = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(busy_a == 0 && chop_a == 0 && sleep_a == 0 && done_a == 0,
              "R1 mid-run reset idle", {busy_a, chop_a, sleep_a, done_a}, 0);
        check(res_a == 0, "R1 mid-run reset clears result", res_a, 0);
        rst = 1'b0;
        run_conv(0, 4, 1056, 1'b0, 1'b0, "R1 clean conversion after reset");

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule